// File: doc/BRIEF.md
# HDLC Bit-Serial Frame Transmitter

This block takes bytes from a host, holds them in a small queue and sends them out one bit per clock as bit-oriented HDLC frames. Each queued entry holds a data byte, an end-of-packet mark and an abort mark. In packet modes the block frames the bytes itself. It sends an opening flag and then the data least significant bit first. It follows the data with a 16-bit check sequence and a closing flag, and it puts a zero after every run of five ones inside the frame body.

Between frames the line carries a fill pattern that the host chooses: repeated flags, continuous ones, or go-ahead bytes. While go-ahead is chosen, queued data is held back. A fourth setting turns framing off completely. In that transparent setting the bytes are shifted out raw, cut down to their low 2, 6 or 7 bits if the host asks for that. When the queue is empty, the last byte taken is sent again. If a packet runs dry before its end mark arrives, the block ends it with an abort. The host can also ask for an abort explicitly by marking the next byte it writes. A registered low-level status tells the host when it may refill the queue.

Top module: `hdlc_tx`

## Requirements
- R1: The queue holds 19 entries, each a byte with an end-of-packet mark and an abort mark. Entries leave in write order. A write that arrives while all 19 entries are occupied is discarded.
- R2: `fifo_low` is 1 while the queue holds 4 or fewer entries and 0 otherwise. It is registered and reflects a write or read in the cycle that follows it.
- R3: With `fill_sel` = 0 the idle line carries back-to-back flags 0x7E, sent LSB first.
- R4: With `fill_sel` = 1 the idle line is continuous ones. With `fill_sel` = 2 it carries back-to-back 0x7F bytes (go-ahead) and no entry is read from the queue, even if the queue holds data.
- R5: A frame starts only in fill settings 0 or 1 with `tx_en` high and the queue not empty. It is made of a flag, the data bytes LSB first, the ones-complement of a CRC-16 (polynomial x^16+x^12+x^5+1, preset to all ones, bits taken LSB first) sent LSB first, and a closing flag.
- R6: Inside data and check-sequence bits, a 0 follows every five consecutive ones. Flags, aborts and fill get no inserted zeros.
- R7: If the queue is empty when the next byte of an unfinished packet is needed, the block sends 0xFF (an abort) and then returns to the selected fill.
- R8: A pulse on `abort_set` marks the next written byte, and only that byte. When the marked byte reaches the head, it is dropped and 0xFF is sent in its place, ending the frame. Later bytes form a new frame.
- R9: With `fill_sel` = 3 and `tx_en` high, bytes are sent LSB first with no flags, no inserted zeros and no check sequence. When the queue is empty, the last byte taken is repeated.
- R10: In transparent mode, `tbits_sel` values 2, 6 and 7 send only that many low bits of each byte. All other codes (including 1) send 8 bits.
- R11: When `tx_en` goes low, transparent output becomes 1 in the next cycle. A frame already started still completes.
- R12: After reset, `tx_bit` is 1, `fifo_low` is 1 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to write |
| wr_eop | input | 1 | Byte ends its packet |
| abort_set | input | 1 | Mark the next written byte as an abort |
| tx_en | input | 1 | Transmit enable |
| fill_sel | input | 2 | 0 flags, 1 ones, 2 go-ahead, 3 transparent |
| tbits_sel | input | 3 | Transparent bits per byte: 2, 6, 7, else 8 |
| tx_bit | output | 1 | Registered serial line output |
| fifo_low | output | 1 | Queue holds 4 or fewer entries |

## Verification
A bit-level receiver model in the bench strips inserted zeros, finds flags and aborts, and checks each frame's CRC residue and contents against a queue of expected packets. Random packets, with extra 0xFF and flag-like bytes, separate correct zero insertion from a missing or misplaced zero. Directed runs cover underrun, marked aborts, a full queue and a go-ahead hold; each shows whether a frame was kept or cut. Fill and transparent outputs are checked as periodic patterns, so a wrong bit count per byte, a wrong bit order or stuffing in raw mode each break the period or the rotation match.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;

  localparam logic [1:0] FILL_FLAG    = 2'd0;
  localparam logic [1:0] FILL_IDLE    = 2'd1;
  localparam logic [1:0] FILL_GOAHEAD = 2'd2;
  localparam logic [1:0] FILL_TRANSP  = 2'd3;

  localparam logic [BYTE_W-1:0] PAT_FLAG    = 8'h7E;
  localparam logic [BYTE_W-1:0] PAT_ONES    = 8'hFF;
  localparam logic [BYTE_W-1:0] PAT_GOAHEAD = 8'h7F;

  // bit-reversed form of x^16+x^12+x^5+1 for LSB-first shifting
  localparam logic [FCS_W-1:0] FCS_POLY_REFL = 16'h8408;

  typedef struct packed {
    logic              abort;
    logic              eop;
    logic [BYTE_W-1:0] data;
  } tx_entry_t;

  typedef enum logic [2:0] {
    S_FILL, S_OPEN, S_DATA, S_FCS, S_CLOSE, S_ABORT, S_TRANS
  } ser_state_e;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH    = 19,
  parameter int W        = 10,
  parameter int LOW_MARK = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         low
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nxt;
  logic          wr_ok, rd_ok;

  assign wr_ok     = wr_en && (count != CW'(DEPTH));
  assign rd_ok     = rd_en && (count != '0);
  assign count_nxt = count + CW'(wr_ok) - CW'(rd_ok);
  assign empty     = (count == '0);
  assign rd_data   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      low    <= 1'b1;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      count <= count_nxt;
      low   <= (count_nxt <= CW'(LOW_MARK));
    end
  end

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && wr_en && !rd_en) |=> (count == CW'(DEPTH)));

  // R1
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] next
);
  logic [W-1:0] crc_q;

  always_comb begin
    next = crc_q;
    if (init) begin
      next = '1;
    end else if (en) begin
      next = crc_q >> 1;
      if (crc_q[0] ^ din) next = next ^ POLY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '1;
    else     crc_q <= next;
  end
endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
  import hdlc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic [1:0] fill_sel,
  input  logic [2:0] tbits_sel,
  input  tx_entry_t head,
  input  logic      empty,
  output logic      pop,
  output logic      tx_bit
);
  localparam int SH_W      = FCS_W;
  localparam int CNT_W     = $clog2(SH_W + 1);
  localparam int STUFF_RUN = 5;

  ser_state_e        st_q, st_n;
  logic [SH_W-1:0]   sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, tlen;
  logic [2:0]        ones_q, ones_n;
  logic              stuff_unit_q, stuff_unit_n;
  logic              stuff_pend_q, stuff_pend_n;
  logic              eop_q, eop_n;
  logic [BYTE_W-1:0] last_q, last_n;
  logic              bit_out, crc_init, crc_en, trans_ok, go_fill;
  logic [BYTE_W-1:0] fill_pat, tbyte;
  logic [FCS_W-1:0]  crc_d;

  assign trans_ok = tx_en && (fill_sel == FILL_TRANSP);
  assign tbyte    = empty ? last_q : head.data;

  always_comb begin
    case (tbits_sel)
      3'd2:    tlen = CNT_W'(2);
      3'd6:    tlen = CNT_W'(6);
      3'd7:    tlen = CNT_W'(7);
      default: tlen = CNT_W'(BYTE_W);
    endcase
    case (fill_sel)
      FILL_FLAG:    fill_pat = PAT_FLAG;
      FILL_GOAHEAD: fill_pat = PAT_GOAHEAD;
      default:      fill_pat = PAT_ONES;
    endcase
  end

  hdlc_tx_fcs #(.W(FCS_W), .POLY(FCS_POLY_REFL)) u_fcs (
    .clk(clk), .rst(rst), .init(crc_init), .en(crc_en),
    .din(sh_q[0]), .next(crc_d)
  );

  always_comb begin
    st_n         = st_q;
    sh_n         = sh_q;
    cnt_n        = cnt_q;
    ones_n       = ones_q;
    stuff_unit_n = stuff_unit_q;
    stuff_pend_n = stuff_pend_q;
    eop_n        = eop_q;
    last_n       = last_q;
    bit_out      = 1'b1;
    pop          = 1'b0;
    crc_init     = 1'b0;
    crc_en       = 1'b0;
    go_fill      = 1'b0;
    if (st_q == S_TRANS && !trans_ok) begin
      // raw mode halts at once: mark the line and restart fill
      st_n         = S_FILL;
      sh_n         = SH_W'(PAT_ONES);
      cnt_n        = CNT_W'(BYTE_W);
      stuff_unit_n = 1'b0;
      stuff_pend_n = 1'b0;
      ones_n       = '0;
    end else if (stuff_pend_q) begin
      bit_out      = 1'b0;
      stuff_pend_n = 1'b0;
      ones_n       = '0;
    end else begin
      bit_out = sh_q[0];
      sh_n    = sh_q >> 1;
      cnt_n   = cnt_q - CNT_W'(1);
      crc_en  = (st_q == S_DATA);
      if (stuff_unit_q && sh_q[0]) begin
        if (ones_q == 3'(STUFF_RUN - 1)) begin
          stuff_pend_n = 1'b1;
          ones_n       = '0;
        end else begin
          ones_n = ones_q + 3'd1;
        end
      end else begin
        ones_n = '0;
      end
      if (cnt_q == CNT_W'(1)) begin
        case (st_q)
          S_OPEN, S_DATA: begin
            if (st_q == S_DATA && eop_q) begin
              st_n         = S_FCS;
              sh_n         = ~crc_d;
              cnt_n        = CNT_W'(FCS_W);
              stuff_unit_n = 1'b1;
            end else if (empty || head.abort) begin
              pop          = !empty;
              st_n         = S_ABORT;
              sh_n         = SH_W'(PAT_ONES);
              cnt_n        = CNT_W'(BYTE_W);
              stuff_unit_n = 1'b0;
            end else begin
              pop          = 1'b1;
              st_n         = S_DATA;
              sh_n         = SH_W'(head.data);
              cnt_n        = CNT_W'(BYTE_W);
              stuff_unit_n = 1'b1;
              eop_n        = head.eop;
            end
          end
          S_FCS: begin
            st_n         = S_CLOSE;
            sh_n         = SH_W'(PAT_FLAG);
            cnt_n        = CNT_W'(BYTE_W);
            stuff_unit_n = 1'b0;
          end
          default: go_fill = 1'b1;
        endcase
        if (go_fill) begin
          stuff_unit_n = 1'b0;
          cnt_n        = CNT_W'(BYTE_W);
          if (trans_ok) begin
            st_n   = S_TRANS;
            pop    = !empty;
            last_n = tbyte;
            sh_n   = SH_W'(tbyte);
            cnt_n  = tlen;
          end else if (tx_en && !empty &&
                       (fill_sel == FILL_FLAG || fill_sel == FILL_IDLE)) begin
            st_n     = S_OPEN;
            sh_n     = SH_W'(PAT_FLAG);
            crc_init = 1'b1;
          end else begin
            st_n = S_FILL;
            sh_n = SH_W'(fill_pat);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= S_FILL;
      sh_q         <= SH_W'(PAT_ONES);
      cnt_q        <= CNT_W'(BYTE_W);
      ones_q       <= '0;
      stuff_unit_q <= 1'b0;
      stuff_pend_q <= 1'b0;
      eop_q        <= 1'b0;
      last_q       <= '0;
      tx_bit       <= 1'b1;
    end else begin
      st_q         <= st_n;
      sh_q         <= sh_n;
      cnt_q        <= cnt_n;
      ones_q       <= ones_n;
      stuff_unit_q <= stuff_unit_n;
      stuff_pend_q <= stuff_pend_n;
      eop_q        <= eop_n;
      last_q       <= last_n;
      tx_bit       <= bit_out;
    end
  end

  // line-side watch of ones runs inside the frame body
  logic       body_q;
  logic [2:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      body_q <= 1'b0;
      run_q  <= '0;
    end else begin
      body_q <= (st_q == S_DATA) || (st_q == S_FCS);
      run_q  <= tx_bit ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
    end
  end

  // R6
  stuff_run_chk: assert property (@(posedge clk) disable iff (rst)
    (body_q && tx_bit) |-> (run_q < 3'(STUFF_RUN)));

  // R4
  goahead_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_FILL && fill_sel == FILL_GOAHEAD) |-> !pop);

  // R8
  tagged_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && head.abort && !trans_ok) |=> (st_q == S_ABORT));

  // R11
  trans_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_TRANS && !tx_en) |=> tx_bit);
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH    = 19,
  parameter int LOW_MARK = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_eop,
  input  logic       abort_set,
  input  logic       tx_en,
  input  logic [1:0] fill_sel,
  input  logic [2:0] tbits_sel,
  output logic       tx_bit,
  output logic       fifo_low
);
  localparam int ENTRY_W = $bits(tx_entry_t);

  logic               arm_q, pop, empty;
  logic [ENTRY_W-1:0] rd_raw;
  tx_entry_t          wr_entry, head;

  always_ff @(posedge clk) begin
    if (rst)            arm_q <= 1'b0;
    else if (wr_en)     arm_q <= 1'b0;
    else if (abort_set) arm_q <= 1'b1;
  end

  assign wr_entry = '{abort: arm_q | abort_set, eop: wr_eop, data: wr_data};
  assign head     = tx_entry_t'(rd_raw);

  hdlc_tx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W), .LOW_MARK(LOW_MARK)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_entry),
    .rd_en(pop), .rd_data(rd_raw), .empty(empty), .low(fifo_low)
  );

  hdlc_tx_serializer u_ser (
    .clk(clk), .rst(rst), .tx_en(tx_en), .fill_sel(fill_sel),
    .tbits_sel(tbits_sel), .head(head), .empty(empty),
    .pop(pop), .tx_bit(tx_bit)
  );
endmodule

// File: tb/sim_hdlc_tx.sv
module sim_hdlc_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_eop = 1'b0, abort_set = 1'b0, tx_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] fill_sel = 2'd0;
  logic [2:0] tbits_sel = 3'd0;
  logic tx_bit, fifo_low;

  always #10 clk = ~clk;

  hdlc_tx u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .abort_set(abort_set), .tx_en(tx_en), .fill_sel(fill_sel),
    .tbits_sel(tbits_sel), .tx_bit(tx_bit), .fifo_low(fifo_low)
  );

  int checks = 0, errors = 0;
  int n_frames = 0, n_aborts = 0;
  int exp_len_q[$];
  logic [7:0] exp_b_q[$];
  logic win [0:63];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  // receiver model
  logic rbits [0:1023];
  int nb = 0, ones = 0;
  bit in_frame = 0;

  task automatic frame_done();
    int nbytes;
    logic [15:0] c;
    logic [7:0] b;
    bit ok;
    int elen;
    nbytes = nb / 8;
    c = 16'hFFFF;
    for (int k = 0; k < nbytes; k++) begin
      b = '0;
      for (int j = 0; j < 8; j++) b[j] = rbits[k*8 + j];
      c = crc_byte(c, b);
    end
    n_frames++;
    chk(c == 16'hF0B8, "R5", "frame check residue", c, 16'hF0B8);
    if (exp_len_q.size() == 0) begin
      chk(0, "R5", "unexpected frame length", nbytes - 2, 0);
      return;
    end
    elen = exp_len_q.pop_front();
    ok = (elen == nbytes - 2);
    for (int k = 0; k < elen; k++) begin
      logic [7:0] e;
      e = exp_b_q.pop_front();
      b = '0;
      if (k < nbytes - 2) for (int j = 0; j < 8; j++) b[j] = rbits[k*8 + j];
      if (b != e) ok = 0;
    end
    chk(ok, "R5", "frame contents / length", nbytes - 2, elen);
  endtask

  always @(negedge clk) begin
    if (rst) begin
      nb = 0; ones = 0; in_frame = 0;
    end else if (tx_bit) begin
      ones++;
      if (ones == 7 && in_frame) begin
        n_aborts++;
        in_frame = 0;
      end
      if (nb < 1024) begin rbits[nb] = 1'b1; nb++; end
    end else begin
      if (ones == 5) begin
        // inserted zero, dropped
      end else if (ones == 6) begin
        nb = (nb >= 7) ? nb - 7 : 0;
        if (in_frame && nb >= 24 && (nb % 8) == 0) frame_done();
        in_frame = 1;
        nb = 0;
      end else if (ones >= 7) begin
        nb = 0;
      end else if (nb < 1024) begin
        rbits[nb] = 1'b0; nb++;
      end
      ones = 0;
    end
  end

  task automatic put(input logic [7:0] d, input logic e);
    wr_en = 1'b1; wr_data = d; wr_eop = e;
    @(negedge clk);
    wr_en = 1'b0; wr_eop = 1'b0;
  endtask

  task automatic put_frame(input int len, input bit ff_bias);
    exp_len_q.push_back(len);
    for (int k = 0; k < len; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (ff_bias && ($urandom % 3 == 0)) d = 8'hFF;
      exp_b_q.push_back(d);
      put(d, k == len - 1);
    end
  endtask

  task automatic grab(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      win[i] = tx_bit;
    end
  endtask

  task automatic check_pat(input logic [7:0] pat, input int p, input string req,
                           input string what);
    bit per, found;
    int packed16;
    per = 1; found = 0; packed16 = 0;
    for (int i = 0; i < 2*p; i++) if (win[i] != win[i+p]) per = 0;
    for (int r = 0; r < p; r++) begin
      bit m;
      m = 1;
      for (int j = 0; j < p; j++) if (win[r+j] != pat[j]) m = 0;
      if (m) found = 1;
    end
    for (int i = 0; i < 16; i++) packed16 |= int'(win[i]) << i;
    chk(per && found, req, what, packed16, int'(pat));
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (exp_len_q.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (40) @(negedge clk);
    chk(exp_len_q.size() == 0, "R5", "expected frames all received",
        exp_len_q.size(), 0);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0, a0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(tx_bit == 1'b1, "R12", "line idle after reset", tx_bit, 1);
    chk(fifo_low == 1'b1, "R12", "low status after reset", fifo_low, 1);

    // R3 flag fill
    repeat (20) @(negedge clk);
    grab(24);
    check_pat(8'h7E, 8, "R3", "flag fill");

    // R4 all-ones fill
    fill_sel = 2'd1;
    repeat (20) @(negedge clk);
    grab(24);
    check_pat(8'hFF, 8, "R4", "ones fill");

    // R1 / R2 threshold and full queue, transmitter held off
    fill_sel = 2'd0;
    repeat (10) @(negedge clk);
    exp_len_q.push_back(19);
    for (int k = 0; k < 25; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (k < 19) exp_b_q.push_back(d);
      put(d, k >= 18);
      if (k < 6) chk(fifo_low == (k + 1 <= 4), "R2", "low status vs fill level",
                     fifo_low, (k + 1 <= 4));
    end
    f0 = n_frames;
    tx_en = 1'b1;
    wait_idle();
    chk(n_frames == f0 + 1, "R1", "full queue gives one 19-byte frame", n_frames - f0, 1);
    chk(fifo_low == 1'b1, "R2", "low status after drain", fifo_low, 1);

    // R4 go-ahead holds queued data
    fill_sel = 2'd2;
    repeat (20) @(negedge clk);
    put_frame(6, 0);
    repeat (60) @(negedge clk);
    grab(24);
    check_pat(8'h7F, 8, "R4", "go-ahead fill with data queued");
    chk(fifo_low == 1'b0, "R4", "queue untouched during go-ahead", fifo_low, 0);
    fill_sel = 2'd0;
    wait_idle();

    // R6 directed: long ones runs and flag-like bytes
    exp_len_q.push_back(6);
    exp_b_q.push_back(8'hFF); put(8'hFF, 0);
    exp_b_q.push_back(8'hFF); put(8'hFF, 0);
    exp_b_q.push_back(8'h7E); put(8'h7E, 0);
    exp_b_q.push_back(8'h3F); put(8'h3F, 0);
    exp_b_q.push_back(8'hFC); put(8'hFC, 0);
    exp_b_q.push_back(8'hFF); put(8'hFF, 1);
    f0 = n_frames;
    wait_idle();
    chk(n_frames == f0 + 1, "R6", "ones-heavy frame delivered", n_frames - f0, 1);

    // R5 / R6 random frames, flag fill and ones fill
    for (int n = 0; n < 12; n++) begin
      fill_sel = (n % 2 == 0) ? 2'd0 : 2'd1;
      while (!fifo_low) @(negedge clk);
      put_frame(1 + int'($urandom % 12), 1);
    end
    wait_idle();
    fill_sel = 2'd0;
    repeat (30) @(negedge clk);

    // R7 underrun
    tx_en = 1'b0;
    repeat (10) @(negedge clk);
    put(8'h11, 0); put(8'h22, 0); put(8'h33, 0);
    f0 = n_frames; a0 = n_aborts;
    tx_en = 1'b1;
    repeat (200) @(negedge clk);
    chk(n_aborts == a0 + 1, "R7", "underrun abort seen", n_aborts - a0, 1);
    chk(n_frames == f0, "R7", "no frame from underrun", n_frames - f0, 0);
    put_frame(4, 0);
    wait_idle();

    // R8 marked abort then a new frame
    tx_en = 1'b0;
    repeat (10) @(negedge clk);
    put(8'hA1, 0); put(8'hA2, 0);
    abort_set = 1'b1; @(negedge clk); abort_set = 1'b0;
    put(8'hA3, 0);
    put_frame(3, 0);
    f0 = n_frames; a0 = n_aborts;
    tx_en = 1'b1;
    wait_idle();
    chk(n_aborts == a0 + 1, "R8", "marked byte aborts frame", n_aborts - a0, 1);
    chk(n_frames == f0 + 1, "R8", "mark clears after one write", n_frames - f0, 1);

    // R11 frame completes after enable drops
    tx_en = 1'b0;
    repeat (10) @(negedge clk);
    put_frame(10, 0);
    f0 = n_frames;
    tx_en = 1'b1;
    repeat (40) @(negedge clk);
    tx_en = 1'b0;
    wait_idle();
    chk(n_frames == f0 + 1, "R11", "packet finishes with enable low", n_frames - f0, 1);

    // R9 / R10 transparent
    put(8'h4B, 0);
    fill_sel = 2'd3; tbits_sel = 3'd0;
    tx_en = 1'b1;
    repeat (40) @(negedge clk);
    grab(24);
    check_pat(8'h4B, 8, "R9", "raw byte repeated");
    tbits_sel = 3'd2;
    put(8'hB6, 0);
    repeat (40) @(negedge clk);
    grab(24);
    check_pat(8'h02, 2, "R10", "2 low bits");
    tbits_sel = 3'd7;
    put(8'h4B, 0);
    repeat (40) @(negedge clk);
    grab(24);
    check_pat(8'h4B, 7, "R10", "7 low bits");
    tbits_sel = 3'd6;
    put(8'h2D, 0);
    repeat (40) @(negedge clk);
    grab(24);
    check_pat(8'h2D, 6, "R10", "6 low bits");
    tbits_sel = 3'd1;
    put(8'h4B, 0);
    repeat (40) @(negedge clk);
    grab(24);
    check_pat(8'h4B, 8, "R10", "code 1 sends 8 bits");
    tbits_sel = 3'd0;
    put(8'hFF, 0);
    repeat (40) @(negedge clk);
    grab(24);
    check_pat(8'hFF, 8, "R9", "no zero insertion in raw mode");
    tbits_sel = 3'd7;
    put(8'h4B, 0);
    repeat (40) @(negedge clk);
    tx_en = 1'b0;
    grab(8);
    begin
      int z;
      z = 0;
      for (int i = 0; i < 8; i++) if (!win[i]) z++;
      chk(z == 0, "R11", "raw output stops at once", z, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule